// File: doc/BRIEF.md
# External Sync Reset with Field Identification

This block lets a camera's internal sync counters follow an external master that runs from a clock of the same frequency. Two active-low reset inputs, one for lines and one for frames, are brought into the clock domain. Their falling edges produce load pulses for the downstream horizontal and vertical counters. Clock phase locking is not part of the block.

A line reset is accepted only once its input has stayed low for a minimum number of cycles. It then reloads an internal line-position tracker. When a frame reset edge arrives, the block reads that tracker and decides whether the frame restarts in the odd or the even field. It sends the chosen field to the vertical counter together with a line preload value. That preload places the next vertical drive a fixed number of lines later.

Guard bands around each window boundary keep the previous decision. In normal mode the tracker runs freely with the nominal line length. In direct mode it counts from the last line reset without wrapping, so the incoming line period may be any length.

Top module: `esr_ext_reset`

## Requirements
- R1: While `rst_n` is low and after its release with both reset inputs held high, `h_load`, `v_load`, `h_load_val`, `v_load_val` and `field_even` are all 0 (0 means odd field).
- R2: When `hrst_n` is low for at least H_MIN_LOW (7) consecutive clock samples, `h_load` is high for exactly one cycle. It becomes visible H_MIN_LOW+2 rising edges after the first sample that sees the input low.
- R3: A low pulse on `hrst_n` shorter than H_MIN_LOW samples produces no `h_load`.
- R4: With each `h_load`, `h_load_val` is LINE_LEN-HD_DELAY (79) in normal mode, so the next internal line drive comes 701 cycles later. In direct mode it is 0. The line tracker takes the same value.
- R5: A falling edge on `vrst_n` gives one `v_load` pulse, visible 3 rising edges after the first sample that sees the input low. The field decision updates in the same cycle.
- R6: Normal mode: the tracker position p at the frame reset edge counts 0..LINE_LEN-1 and wraps. The decision is odd if GUARD ≤ p < FLD_SPLIT-GUARD (5..263). It is even if FLD_SPLIT+GUARD ≤ p < FLD_SPLIT+EVEN_SPAN-GUARD (274..651).
- R7: Direct mode: p counts from the last accepted line reset and saturates rather than wrapping. The decision is odd for 5 ≤ p < 264 and even for every p ≥ 274, with no upper limit.
- R8: A frame reset edge with p in a guard region leaves `field_even` unchanged. In normal mode the guard regions are p < 5, 264..273 and p ≥ 652. In direct mode they are p < 5 and 264..273. Outside frame reset edges, `field_even` never changes.
- R9: With each `v_load`, `v_load_val` is FRAME_LINES-VD_LINES (516) for odd and EVEN_START-VD_LINES (253) for even, so the vertical drive follows 9 lines later in either field.
- R10: A frame reset input held low for many cycles yields only one `v_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hrst_n | input | 1 | External line reset, active on falling edge, asynchronous |
| vrst_n | input | 1 | External frame reset, active on falling edge, asynchronous |
| direct_mode | input | 1 | 1 selects direct mode (any line period), 0 normal mode |
| h_load | output | 1 | One-cycle load strobe to the horizontal counter |
| h_load_val | output | 11 | Horizontal counter preload |
| v_load | output | 1 | One-cycle load strobe to the vertical counter |
| v_load_val | output | 10 | Vertical line counter preload for the chosen field |
| field_even | output | 1 | Current field decision, 1 = even |

## Verification
The line load strobe is due H_MIN_LOW+2 edges (9 cycles) after the line reset input is driven low. The frame strobe, field decision and vertical preload are due 3 edges after the frame reset input falls. Both strobes must be gone one cycle later. The bench drives inputs on falling clock edges and counts exactly those falling edges before sampling. It sets the gap between line and frame reset so that the tracker position p = 72 + gap (normal mode, wrapping) or gap - 7 (direct mode) lands in a chosen window or guard band.

// File: rtl/esr_pkg.sv
package esr_pkg;
    typedef enum logic [1:0] {
        VOTE_KEEP = 2'd0,
        VOTE_ODD  = 2'd1,
        VOTE_EVEN = 2'd2
    } fld_vote_t;
endpackage

// File: rtl/esr_sync.sv
module esr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        if (STAGES > 1) chain_d = {chain_q[STAGES-2:0], din};
        else            chain_d = din;
        lvl = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/esr_hqual.sv
module esr_hqual #(
    parameter int MIN_LOW = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fire
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW);
    localparam logic [CW-1:0] CNT_FIRE = CW'(MIN_LOW - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (lvl)                  cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        fire = !lvl && (cnt_q == CNT_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_QUAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R2
endmodule

// File: rtl/esr_hpos.sv
module esr_hpos #(
    parameter int LINE_LEN = 780,
    parameter int HD_DELAY = 701,
    parameter int POS_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             direct,
    input  logic             load,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] RELOAD = POS_W'(LINE_LEN - HD_DELAY);
    localparam logic [POS_W-1:0] LAST   = POS_W'(LINE_LEN - 1);
    localparam logic [POS_W-1:0] TOP    = '1;

    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        if (load)             pos_d = direct ? '0 : RELOAD;
        else if (direct)      pos_d = (pos_q == TOP) ? pos_q : pos_q + 1'b1;
        else if (pos_q >= LAST) pos_d = '0;
        else                  pos_d = pos_q + 1'b1;
        pos = pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && !load && pos_q == LAST) |=> (pos_q == '0)); // R6
    AST_POS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !direct) |=> (pos_q == RELOAD)); // R4
    AST_POS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && !load && pos_q == TOP) |=> (pos_q == TOP)); // R7
endmodule

// File: rtl/esr_fieldsel.sv
module esr_fieldsel
    import esr_pkg::*;
#(
    parameter int FLD_SPLIT = 269,
    parameter int EVEN_SPAN = 388,
    parameter int GUARD     = 5,
    parameter int POS_W     = 11
) (
    input  logic [POS_W-1:0] pos,
    input  logic             direct,
    output fld_vote_t        vote
);
    localparam logic [POS_W-1:0] ODD_LO  = POS_W'(GUARD);
    localparam logic [POS_W-1:0] ODD_HI  = POS_W'(FLD_SPLIT - GUARD);
    localparam logic [POS_W-1:0] EVEN_LO = POS_W'(FLD_SPLIT + GUARD);
    localparam logic [POS_W-1:0] EVEN_HI = POS_W'(FLD_SPLIT + EVEN_SPAN - GUARD);

    logic odd_ok, even_ok;

    always_comb begin
        odd_ok  = (pos >= ODD_LO) && (pos < ODD_HI);
        even_ok = (pos >= EVEN_LO) && (direct || (pos < EVEN_HI));
        if (odd_ok)       vote = VOTE_ODD;
        else if (even_ok) vote = VOTE_EVEN;
        else              vote = VOTE_KEEP;
    end
endmodule

// File: rtl/esr_ext_reset.sv
module esr_ext_reset
    import esr_pkg::*;
#(
    parameter int LINE_LEN    = 780,
    parameter int HD_DELAY    = 701,
    parameter int H_MIN_LOW   = 7,
    parameter int FLD_SPLIT   = 269,
    parameter int EVEN_SPAN   = 388,
    parameter int GUARD       = 5,
    parameter int FRAME_LINES = 525,
    parameter int EVEN_START  = 262,
    parameter int VD_LINES    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hrst_n,
    input  logic                           vrst_n,
    input  logic                           direct_mode,
    output logic                           h_load,
    output logic [$clog2(LINE_LEN):0]      h_load_val,
    output logic                           v_load,
    output logic [$clog2(FRAME_LINES)-1:0] v_load_val,
    output logic                           field_even
);
    localparam int POS_W = $clog2(LINE_LEN) + 1;
    localparam int LN_W  = $clog2(FRAME_LINES);
    localparam logic [POS_W-1:0] H_RELOAD = POS_W'(LINE_LEN - HD_DELAY);
    localparam logic [LN_W-1:0]  ODD_VAL  = LN_W'(FRAME_LINES - VD_LINES);
    localparam logic [LN_W-1:0]  EVEN_VAL = LN_W'(EVEN_START - VD_LINES);

    typedef struct packed {
        logic             h_load;
        logic [POS_W-1:0] h_val;
        logic             v_load;
        logic [LN_W-1:0]  v_val;
        logic             field_even;
        logic             v_prev;
    } st_t;

    st_t st_d, st_q;

    logic             h_lvl, v_lvl, h_fire, v_fall;
    logic [POS_W-1:0] pos;
    fld_vote_t        vote;

    esr_sync #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst_n(rst_n), .din(hrst_n), .lvl(h_lvl));
    esr_sync #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst_n(rst_n), .din(vrst_n), .lvl(v_lvl));

    esr_hqual #(.MIN_LOW(H_MIN_LOW)) u_hqual (
        .clk(clk), .rst_n(rst_n), .lvl(h_lvl), .fire(h_fire));

    esr_hpos #(.LINE_LEN(LINE_LEN), .HD_DELAY(HD_DELAY), .POS_W(POS_W)) u_hpos (
        .clk(clk), .rst_n(rst_n), .direct(direct_mode), .load(h_fire), .pos(pos));

    esr_fieldsel #(.FLD_SPLIT(FLD_SPLIT), .EVEN_SPAN(EVEN_SPAN), .GUARD(GUARD),
                   .POS_W(POS_W)) u_fsel (
        .pos(pos), .direct(direct_mode), .vote(vote));

    always_comb begin
        st_d        = st_q;
        v_fall      = st_q.v_prev && !v_lvl;
        st_d.v_prev = v_lvl;
        st_d.h_load = h_fire;
        if (h_fire) st_d.h_val = direct_mode ? '0 : H_RELOAD;
        st_d.v_load = v_fall;
        if (v_fall) begin
            case (vote)
                VOTE_ODD:  st_d.field_even = 1'b0;
                VOTE_EVEN: st_d.field_even = 1'b1;
                default:   st_d.field_even = st_q.field_even;
            endcase
            st_d.v_val = st_d.field_even ? EVEN_VAL : ODD_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.v_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_load     = st_q.h_load;
    assign h_load_val = st_q.h_val;
    assign v_load     = st_q.v_load;
    assign v_load_val = st_q.v_val;
    assign field_even = st_q.field_even;

    AST_VLOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        v_load |=> !v_load); // R10
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !v_load |-> $stable(field_even)); // R8
    AST_VVAL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        v_load |-> (v_load_val == (field_even ? EVEN_VAL : ODD_VAL))); // R9
    AST_HVAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        h_load |-> (h_load_val == H_RELOAD || h_load_val == '0)); // R4
    AST_HLOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        h_load |=> !h_load); // R2
endmodule

// File: tb/tb_esr_ext_reset.sv
`timescale 1ns/1ps
module tb_esr_ext_reset;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hrst_n = 1'b1;
    logic vrst_n = 1'b1;
    logic direct_mode = 1'b0;
    logic        h_load, v_load, field_even;
    logic [10:0] h_load_val;
    logic [9:0]  v_load_val;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    esr_ext_reset dut (
        .clk(clk), .rst_n(rst_n), .hrst_n(hrst_n), .vrst_n(vrst_n),
        .direct_mode(direct_mode), .h_load(h_load), .h_load_val(h_load_val),
        .v_load(v_load), .v_load_val(v_load_val), .field_even(field_even));

    // {direct, gap between line and frame reset (negedges), expected field_even}
    // normal: p = (72 + gap) mod 780 ; direct: p = gap - 7
    localparam logic [13:0] VEC [15] = '{
        {1'b0, 12'd100,  1'b0},  // R6 p=172 odd
        {1'b0, 12'd300,  1'b1},  // R6 p=372 even
        {1'b0, 12'd195,  1'b1},  // R8 p=267 guard, keep even
        {1'b0, 12'd150,  1'b0},  // R6 p=222 odd
        {1'b0, 12'd585,  1'b0},  // R8 p=657 guard, keep odd
        {1'b0, 12'd500,  1'b1},  // R6 p=572 even
        {1'b0, 12'd710,  1'b1},  // R8 p=2 after wrap, keep even
        {1'b0, 12'd720,  1'b0},  // R6 p=12 after wrap, odd
        {1'b1, 12'd100,  1'b0},  // R7 p=93 odd
        {1'b1, 12'd1500, 1'b1},  // R7 p=1493 even, long period
        {1'b1, 12'd275,  1'b1},  // R8 p=268 guard, keep
        {1'b1, 12'd9,    1'b1},  // R8 p=2 guard, keep
        {1'b1, 12'd20,   1'b0},  // R7 p=13 odd
        {1'b1, 12'd290,  1'b1},  // R7 p=283 even
        {1'b1, 12'd700,  1'b1}   // R7 p=693 even (normal mode would be guard)
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic run_vec(input logic dm, input int gap, input logic exp_even);
        int exp_vval;
        exp_vval = exp_even ? 253 : 516;
        direct_mode = dm;
        repeat (3) @(negedge clk);
        hrst_n = 1'b0;
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            if (i == 8) hrst_n = 1'b1;
            if (i == 9) begin
                chk("R2 h_load pulse", h_load, 1);
                chk("R4 h_load_val", h_load_val, dm ? 0 : 79);
            end
            if (i == 10) chk("R2 h_load single", h_load, 0);
        end
        vrst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 v_load not early", v_load, 0);
        @(negedge clk);
        chk("R5 v_load pulse", v_load, 1);
        chk("R6/R7/R8 field_even", field_even, exp_even);
        chk("R9 v_load_val", v_load_val, exp_vval);
        @(negedge clk);
        chk("R10 v_load single", v_load, 0);
        vrst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic h_pulse(input int width, output int seen);
        seen = 0;
        hrst_n = 1'b0;
        repeat (width) @(negedge clk);
        hrst_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (h_load) seen++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seen;
        int pulses;
        repeat (3) @(negedge clk);
        chk("R1 reset h_load", h_load, 0);
        chk("R1 reset v_load", v_load, 0);
        chk("R1 reset field_even", field_even, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle h_load_val", h_load_val, 0);
        chk("R1 idle v_load_val", v_load_val, 0);
        chk("R1 idle field_even", field_even, 0);

        // table walk
        for (int k = 0; k < 15; k++)
            run_vec(VEC[k][13], int'(VEC[k][12:1]), VEC[k][0]);

        // R3: too-short line reset pulse is ignored
        direct_mode = 1'b0;
        h_pulse(6, seen);
        chk("R3 short pulse ignored", seen, 0);
        // R2: exactly the minimum width is accepted once
        h_pulse(7, seen);
        chk("R2 min width accepted", seen, 1);

        // R10: frame reset held low for a long time gives one strobe
        pulses = 0;
        vrst_n = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (v_load) pulses++;
        end
        vrst_n = 1'b1;
        chk("R10 held low one v_load", pulses, 1);
        repeat (5) @(negedge clk);

        // R1: reset reasserted mid-run returns to idle state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset field_even", field_even, 0);
        chk("R1 re-reset v_load_val", v_load_val, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule